// File: doc/BRIEF.md
# Serial Shadow-RAM Command Interface

This block is the device-side front end of a small shadow RAM of 16 words by 16 bits, reached over a three-wire serial link: a chip select, a serial clock and a data input, plus a data output with its own enable. The serial clock is slow and may stop at any time. It is sampled on the fast system clock, and the block acts on its edges. When chip select rises, the block hunts for a leading one. It then shifts in an eight-bit instruction, most significant bit first. The instruction carries a four-bit word address and a three-bit operation code.

Reads and writes act on the word array inside the block. The four non-data operations do not act on it. Instead each raises a one-cycle request toward logic outside the block, which owns the nonvolatile copy and the protection latches. That outside logic answers with two inputs. `write_permit` allows RAM writes. `busy` marks a store in progress, and during a store every serial command is ignored. A write is committed when chip select falls, so a short write still updates the word.

Top module: `snv_serial_if`

## Requirements
- R1: While `ce` is low, the interface returns to hunting and drops any partly received instruction. A new command always starts after a `ce` low period.
- R2: After `ce` rises, zeros sampled on rising `sk` edges are ignored. The first one sampled is taken as instruction bit 7.
- R3: The instruction is 8 bits, sampled on rising `sk`, MSB first. Bit 7 is 1, bits 6..3 carry the word address, and bits 2..0 carry the operation code.
- R4: Operation codes 000, 001, 100 and 101 each raise a single-cycle pulse, on `req_wrds`, `req_store`, `req_wren` and `req_recall` respectively. Code 010 raises nothing. At most one request is high at a time.
- R5: Codes 110 and 111 both read, so instruction bit 0 is ignored. Data bit 0 appears on `dout` after the falling `sk` edge of the 8th clock. Each following rising edge presents the next bit, LSB first. After bit 15 the sequence wraps to bit 0.
- R6: `dout_en` is high only while read data is being shifted out. It is low during the instruction and while `ce` is low.
- R7: Code 011 takes data bits LSB first on the rising `sk` edges after the instruction. The word is written to the addressed location when `ce` falls.
- R8: If `ce` falls before all 16 data bits have arrived, the bits received are written. Positions not received keep their previous value.
- R9: Data bits beyond the 16th wrap around and overwrite positions from bit 0 upward.
- R10: When `write_permit` is low at the commit, the write is dropped and the word is unchanged.
- R11: While `busy` is high, no command starts or completes. No request pulses, no data is output and no word is written.
- R12: The serial clock is static. Stopping `sk` for any time between edges does not change the result of a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip select, high during a command |
| sk | input | 1 | Serial clock, sampled on `clk` |
| di | input | 1 | Serial data in |
| write_permit | input | 1 | High when the protection latches allow RAM writes |
| busy | input | 1 | High while a store is in progress |
| dout | output | 1 | Serial read data |
| dout_en | output | 1 | Output enable for `dout` (high impedance when low) |
| req_store | output | 1 | One-cycle store request |
| req_recall | output | 1 | One-cycle recall request |
| req_wren | output | 1 | One-cycle request to set write enable |
| req_wrds | output | 1 | One-cycle request to clear write enable |

## Verification
A bit counter that is off by one shows in two ways. A read places its first bit on the wrong edge, which appears within one `sk` period after the 8th clock. A write puts data into the wrong positions, which appears on the next read of that word. If the state fails to clear when `ce` drops, the next command is decoded from stale bits, so a request pulse is missing or wrong at the 8th clock of that command. A wrongly gated commit is not visible at the time, and only a later read of the same address exposes it. For that reason the sweep reads back every address after it is written.

// File: rtl/snv_pkg.sv
package snv_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 16;
    localparam int OPC_W   = 3;
    localparam int INSTR_W = 1 + ADDR_W + OPC_W;

    typedef enum logic [2:0] {
        ST_HUNT, ST_INSTR, ST_RBIT8, ST_RFALL, ST_RDATA, ST_WDATA, ST_DONE
    } state_e;

    typedef enum logic [2:0] {
        OP_WRDS  = 3'b000,
        OP_STORE = 3'b001,
        OP_RSVD  = 3'b010,
        OP_WRITE = 3'b011,
        OP_WREN  = 3'b100,
        OP_RCL   = 3'b101,
        OP_RD0   = 3'b110,
        OP_RD1   = 3'b111
    } opcode_e;

    typedef struct packed {
        logic store;
        logic recall;
        logic wren;
        logic wrds;
    } req_t;

    // The two upper opcode bits alone identify a read.
    function automatic logic op_is_read(input logic [1:0] upper);
        return upper == 2'b11;
    endfunction
endpackage

// File: rtl/snv_sync.sv
module snv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic sk,
    input  logic di,
    output logic ce_s,
    output logic di_s,
    output logic sk_rise,
    output logic sk_fall
);
    logic [STAGES-1:0] ce_q, di_q, sk_q;
    logic              sk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q <= '0;
            di_q <= '0;
            sk_q <= '0;
            sk_d <= 1'b0;
        end else begin
            ce_q <= {ce_q[STAGES-2:0], ce};
            di_q <= {di_q[STAGES-2:0], di};
            sk_q <= {sk_q[STAGES-2:0], sk};
            sk_d <= sk_q[STAGES-1];
        end
    end

    assign ce_s    = ce_q[STAGES-1];
    assign di_s    = di_q[STAGES-1];
    assign sk_rise = sk_q[STAGES-1] & ~sk_d;
    assign sk_fall = ~sk_q[STAGES-1] & sk_d;
endmodule

// File: rtl/snv_ram.sv
module snv_ram #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/snv_serial_if.sv
module snv_serial_if
    import snv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic sk,
    input  logic di,
    input  logic write_permit,
    input  logic busy,
    output logic dout,
    output logic dout_en,
    output logic req_store,
    output logic req_recall,
    output logic req_wren,
    output logic req_wrds
);
    localparam int CNT_W = $clog2(INSTR_W + 1);
    localparam int POS_W = $clog2(DATA_W);

    logic ce_s, di_s, sk_rise, sk_fall;

    snv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ce(ce), .sk(sk), .di(di),
        .ce_s(ce_s), .di_s(di_s), .sk_rise(sk_rise), .sk_fall(sk_fall)
    );

    state_e              state;
    logic [INSTR_W-2:0]  instr;
    logic [INSTR_W-1:0]  shifted;
    logic [CNT_W-1:0]    cnt;
    logic [DATA_W-1:0]   rword, wbuf;
    logic [POS_W-1:0]    rpos, wpos;
    logic [ADDR_W-1:0]   waddr, raddr;
    logic [DATA_W-1:0]   ram_rdata;
    logic                ram_we;
    req_t                req;
    logic                at_bit7, at_bit8;

    assign shifted = {instr, di_s};
    assign at_bit7 = (cnt == CNT_W'(INSTR_W - 2));
    assign at_bit8 = (cnt == CNT_W'(INSTR_W - 1));
    assign raddr   = at_bit7 ? shifted[OPC_W-1 +: ADDR_W] : shifted[OPC_W +: ADDR_W];
    // Commit happens in the cycle that chip select is seen low.
    assign ram_we  = !ce_s && (state == ST_WDATA) && write_permit && !busy;

    snv_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk(clk), .we(ram_we), .waddr(waddr), .wdata(wbuf),
        .raddr(raddr), .rdata(ram_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HUNT;
            instr   <= '0;
            cnt     <= '0;
            rword   <= '0;
            wbuf    <= '0;
            rpos    <= '0;
            wpos    <= '0;
            waddr   <= '0;
            dout    <= 1'b0;
            dout_en <= 1'b0;
            req     <= '0;
        end else begin
            req <= '0;
            if (!ce_s) begin
                state   <= ST_HUNT;
                instr   <= '0;
                cnt     <= '0;
                dout    <= 1'b0;
                dout_en <= 1'b0;
            end else begin
                unique case (state)
                    ST_HUNT: if (sk_rise && di_s && !busy) begin
                        instr <= (INSTR_W-1)'(1);
                        cnt   <= CNT_W'(1);
                        state <= ST_INSTR;
                    end
                    ST_INSTR: if (sk_rise) begin
                        instr <= shifted[INSTR_W-2:0];
                        cnt   <= cnt + CNT_W'(1);
                        if (at_bit7 && op_is_read(shifted[1:0])) begin
                            rword <= ram_rdata;
                            state <= busy ? ST_DONE : ST_RBIT8;
                        end else if (at_bit8) begin
                            state <= ST_DONE;
                            if (shifted[INSTR_W-1] && !busy) begin
                                unique case (opcode_e'(shifted[OPC_W-1:0]))
                                    OP_WRDS:  req.wrds   <= 1'b1;
                                    OP_STORE: req.store  <= 1'b1;
                                    OP_WREN:  req.wren   <= 1'b1;
                                    OP_RCL:   req.recall <= 1'b1;
                                    OP_WRITE: begin
                                        wbuf  <= ram_rdata;
                                        waddr <= shifted[OPC_W +: ADDR_W];
                                        wpos  <= '0;
                                        state <= ST_WDATA;
                                    end
                                    default: ;
                                endcase
                            end
                        end
                    end
                    ST_RBIT8: if (sk_rise) state <= ST_RFALL;
                    ST_RFALL: if (sk_fall) begin
                        dout    <= rword[0];
                        dout_en <= 1'b1;
                        rpos    <= POS_W'(1);
                        state   <= ST_RDATA;
                    end
                    ST_RDATA: if (sk_rise) begin
                        dout <= rword[rpos];
                        rpos <= rpos + POS_W'(1);
                    end
                    ST_WDATA: if (sk_rise) begin
                        wbuf[wpos] <= di_s;
                        wpos       <= wpos + POS_W'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign req_store  = req.store;
    assign req_recall = req.recall;
    assign req_wren   = req.wren;
    assign req_wrds   = req.wrds;
endmodule

// File: rtl/snv_serial_if_chk.sv
module snv_serial_if_chk (
    input logic       clk,
    input logic       rst,
    input logic       ce_s,
    input logic       sk_fall,
    input logic       busy,
    input logic       dout_en,
    input logic       ram_we,
    input logic [3:0] reqs
);
    assert_req_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reqs));

    assert_req_single_R4: assert property (@(posedge clk) disable iff (rst)
        (|reqs) |=> !(|reqs));

    assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (rst)
        (|reqs) |-> !$past(busy));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !ce_s |=> !dout_en);

    assert_first_bit_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_en) |-> $past(sk_fall));

    assert_commit_once_R7: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);
endmodule

bind snv_serial_if snv_serial_if_chk u_chk (
    .clk(clk), .rst(rst), .ce_s(ce_s), .sk_fall(sk_fall), .busy(busy),
    .dout_en(dout_en), .ram_we(ram_we),
    .reqs({req_store, req_recall, req_wren, req_wrds})
);

// File: tb/snv_serial_if_bench.sv
module snv_serial_if_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b0, sk = 1'b0, di = 1'b0;
    logic write_permit = 1'b0, busy = 1'b0;
    logic dout, dout_en, req_store, req_recall, req_wren, req_wrds;

    int n_chk = 0, n_fail = 0, pause = 0;
    int c_store = 0, c_recall = 0, c_wren = 0, c_wrds = 0;

    always #2.5 clk = ~clk;

    snv_serial_if u_snv_serial_if (
        .clk(clk), .rst(rst), .ce(ce), .sk(sk), .di(di),
        .write_permit(write_permit), .busy(busy),
        .dout(dout), .dout_en(dout_en),
        .req_store(req_store), .req_recall(req_recall),
        .req_wren(req_wren), .req_wrds(req_wrds)
    );

    always @(posedge clk) begin
        if (req_store)  c_store++;
        if (req_recall) c_recall++;
        if (req_wren)   c_wren++;
        if (req_wrds)   c_wrds++;
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h3B1D) ^ 16'h5AC7);
    endfunction

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic sk_up(input logic b);
        @(negedge clk) di = b;
        waitn(4 + pause);
        sk = 1'b1;
        waitn(6);
    endtask
    task automatic sk_down();
        sk = 1'b0;
        waitn(6 + pause);
    endtask
    task automatic sk_cycle(input logic b);
        sk_up(b);
        sk_down();
    endtask
    task automatic ce_up();
        @(negedge clk) ce = 1'b1;
        waitn(6);
    endtask
    task automatic ce_down();
        @(negedge clk) ce = 1'b0;
        di = 1'b0;
        waitn(8);
    endtask
    task automatic send8(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) sk_cycle(b[i]);
    endtask

    task automatic wr(input int a, input logic [31:0] v, input int nbits);
        ce_up();
        send8({1'b1, 4'(a), 3'b011});
        for (int i = 0; i < nbits; i++) sk_cycle(v[i]);
        ce_down();
    endtask

    // Reads one word; checks R6 and R5 along the way.
    task automatic rd(input int a, input logic lsb, input int pre, output logic [15:0] w);
        logic [7:0] ins;
        logic wrapbit;
        ins = {1'b1, 4'(a), 2'b11, lsb};
        ce_up();
        for (int i = 0; i < pre; i++) sk_cycle(1'b0);
        for (int i = 7; i >= 1; i--) sk_cycle(ins[i]);
        sk_up(ins[0]);
        chk(dout_en == 1'b0, "R6 no output during instruction", 32'(dout_en), 0);
        sk_down();
        chk(dout_en == 1'b1, "R5 output enabled after 8th falling edge", 32'(dout_en), 1);
        w[0] = dout;
        for (int k = 1; k < 16; k++) begin
            sk_up(1'b0);
            w[k] = dout;
            sk_down();
        end
        sk_up(1'b0);
        wrapbit = dout;
        sk_down();
        chk(wrapbit == w[0], "R5 wrap to bit 0", 32'(wrapbit), 32'(w[0]));
        ce_down();
        chk(dout_en == 1'b0, "R6 output off after ce low", 32'(dout_en), 0);
    endtask

    initial begin
        #(5 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] w, e;
        logic [31:0] v;
        int bs, br, bw, bd;
        waitn(10);
        rst = 1'b0;
        waitn(4);
        chk(dout_en == 1'b0 && {req_store, req_recall, req_wren, req_wrds} == 4'b0,
            "R1 reset state", {dout_en, req_store, req_recall, req_wren, req_wrds}, 0);

        // R7/R3: fill every address, then read all back (R5 bit-0 ignored via alternating lsb)
        write_permit = 1'b1;
        for (int a = 0; a < 16; a++) wr(a, {16'h0, pat(a)}, 16);
        for (int a = 0; a < 16; a++) begin
            rd(a, a[0], 0, w);
            chk(w == pat(a), "R7 R3 write then read word", w, pat(a));
        end

        // R2: leading zeros before the start bit
        rd(9, 1'b0, 3, w);
        chk(w == pat(9), "R2 leading zeros ignored", w, pat(9));

        // R8: partial write of 5 bits
        wr(2, 32'h16, 5);
        e = {pat(2)[15:5], 5'h16};
        rd(2, 1'b1, 0, w);
        chk(w == e, "R8 partial write keeps upper bits", w, e);

        // R9: 20 data bits wrap
        v = 32'hA_3C59;
        wr(3, v, 20);
        e = {v[15:4], v[19:16]};
        rd(3, 1'b0, 0, w);
        chk(w == e, "R9 overwrite after 16 bits", w, e);

        // R10: write dropped without permit
        write_permit = 1'b0;
        wr(4, {16'h0, ~pat(4)}, 16);
        write_permit = 1'b1;
        rd(4, 1'b0, 0, w);
        chk(w == pat(4), "R10 write dropped without permit", w, pat(4));

        // R4: each non-data opcode
        for (int op = 0; op < 6; op++) begin
            if (op == 3) continue;
            bs = c_store; br = c_recall; bw = c_wren; bd = c_wrds;
            ce_up();
            send8({1'b1, 4'(op * 3), 3'(op)});
            waitn(4);
            ce_down();
            e = 16'({c_store - bs, c_recall - br, c_wren - bw, c_wrds - bd} );
            chk({4'(c_store - bs), 4'(c_recall - br), 4'(c_wren - bw), 4'(c_wrds - bd)} ==
                ((op == 1) ? 16'h1000 : (op == 5) ? 16'h0100 : (op == 4) ? 16'h0010 :
                 (op == 0) ? 16'h0001 : 16'h0000),
                "R4 opcode request pulse",
                {4'(c_store - bs), 4'(c_recall - br), 4'(c_wren - bw), 4'(c_wrds - bd)}, op);
        end

        // R11: busy blocks commands
        busy = 1'b1;
        waitn(4);
        bw = c_wren;
        ce_up(); send8(8'h84); waitn(4); ce_down();
        wr(6, {16'h0, ~pat(6)}, 16);
        busy = 1'b0;
        waitn(4);
        chk(c_wren == bw, "R11 no request while busy", c_wren - bw, 0);
        rd(6, 1'b1, 0, w);
        chk(w == pat(6), "R11 no write while busy", w, pat(6));

        // R1: aborted instruction then fresh command
        bw = c_wren; bs = c_store;
        ce_up();
        sk_cycle(1); sk_cycle(1); sk_cycle(0); sk_cycle(1);
        ce_down();
        ce_up(); send8(8'h84); waitn(4); ce_down();
        chk(c_wren - bw == 1 && c_store == bs, "R1 ce low discards partial instruction",
            c_wren - bw, 1);

        // R12: static clock with long pauses
        pause = 400;
        wr(7, 32'h0000_C3A5, 16);
        pause = 0;
        rd(7, 1'b0, 0, w);
        chk(w == 16'hC3A5, "R12 stopped sk keeps progress", w, 16'hC3A5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule